// File: doc/BRIEF.md
# FIFO Pointer Health Alarm Monitor

This block watches a small FIFO whose read and write addresses are one-hot rings. From the two pointer vectors it works out, every cycle, whether the pointers overlap or sit one or two slots apart. It also flags a write pointer that has lost its single hot bit. Together with two clock-loss inputs, these findings are caught in sticky alarm bits. Software clears a bit by writing a one to its position.

Each of three causes can be enabled to silence the sample path: converter clock loss, data clock loss, and pointer collision. While the aggregate output alarm is set, the data output carries the mid-scale code instead of the incoming sample. A collision alarm stays set until the FIFO has been resynchronised. The resync strobe is passed on as a load command, together with the reload values for both pointers. The monitor runs on one clock, and its pointer inputs are assumed to be synchronised already.

Top module: `fifo_ptr_alarm_mon`

## Requirements
- R1: After reset every bit of `alarm_word` is 0 and `dout` equals `din`.
- R2: When the pointers share a hot bit (collision), `alarm_word[13]` is set on the next clock edge.
- R3: Bit 12 is set on the next edge when the pointers are exactly one ring position apart, in either direction, with no overlap. Bit 11 is set when they are exactly two positions apart, with no closer match. Only the most severe current match is reported: 100 for collision, 010 for distance 1, 001 for distance 2, and 000 for a distance of 3 or 4.
- R4: An all-zero write pointer sets `alarm_word[15]`. A clearing write cannot remove this bit while the pointer is still all zero.
- R5: `conv_clk_lost` sets `alarm_word[10]` and `data_clk_lost` sets `alarm_word[9]`. Both bits are sticky.
- R6: `alarm_word[8]` is set when an enabled cause is present or its sticky bit is set: bit 10 with `en_conv_mute`, bit 9 with `en_data_mute`, or bit 13 with `en_col_mute`. A cause whose enable bit is 0 sets its own bit only.
- R7: `dout` is 16'h8000 while `alarm_word[8]` is 1. Otherwise `dout` equals `din`.
- R8: A write (`clr_we`=1) with a 1 in the position of an alarm bit clears that bit on the next edge, unless the bit's condition is present in that cycle. A 0 in that position leaves the bit unchanged.
- R9: After a collision, a write to clear bit 13 has no effect until a `resync` pulse has been seen in a cycle with no collision.
- R10: `ptr_load` follows `resync`. `wr_init` is 8'b0000_0001 and `rd_init` is 8'b0001_0000, four positions away.
- R11: Bits 14 and 7:0 of `alarm_word` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_ptr | input | 8 | One-hot write pointer |
| rd_ptr | input | 8 | One-hot read pointer |
| conv_clk_lost | input | 1 | Converter clock stopped |
| data_clk_lost | input | 1 | Data clock stopped |
| en_conv_mute | input | 1 | Converter clock loss mutes output |
| en_data_mute | input | 1 | Data clock loss mutes output |
| en_col_mute | input | 1 | Collision mutes output |
| resync | input | 1 | FIFO resynchronisation strobe |
| clr_we | input | 1 | Clear-write strobe |
| clr_data | input | 16 | Bits to clear (1 clears) |
| alarm_word | output | 16 | Alarm readback |
| din | input | 16 | Incoming sample |
| dout | output | 16 | Outgoing sample, muted to mid-scale |
| ptr_load | output | 1 | Load command for the FIFO pointers |
| wr_init | output | 8 | Write pointer reload value |
| rd_init | output | 8 | Read pointer reload value |

## Verification
The assertions check on every cycle that a collision, an all-zero write pointer or an enabled data clock loss reaches its alarm bit or the muted output one edge later. They also check that a clearing write removes the converter clock bit when its condition is gone, and that the collision bit survives until a resync. The bench shows the rest. It sweeps all 64 pairs of one-hot pointers against a ring distance computed arithmetically, checks the mute result for each pair, and covers disabled causes, writes of zero, and clears attempted while a fault persists.

// File: rtl/fifo_ptr_alarm_mon.sv
module fifo_ptr_alarm_mon #(
  parameter int DEPTH = 8,
  parameter int DW = 16,
  parameter int RD_OFFSET = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] wr_ptr,
  input  logic [DEPTH-1:0] rd_ptr,
  input  logic             conv_clk_lost,
  input  logic             data_clk_lost,
  input  logic             en_conv_mute,
  input  logic             en_data_mute,
  input  logic             en_col_mute,
  input  logic             resync,
  input  logic             clr_we,
  input  logic [15:0]      clr_data,
  output logic [15:0]      alarm_word,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             ptr_load,
  output logic [DEPTH-1:0] wr_init,
  output logic [DEPTH-1:0] rd_init
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  function automatic logic [DEPTH-1:0] rotl(input logic [DEPTH-1:0] v, input int n);
    return (v << n) | (v >> (DEPTH - n));
  endfunction

  function automatic logic [DEPTH-1:0] rotr(input logic [DEPTH-1:0] v, input int n);
    return (v >> n) | (v << (DEPTH - n));
  endfunction

  logic collide, one_apart, two_apart, wr_lost;
  logic [2:0] near_now;

  assign collide   = |(wr_ptr & rd_ptr);
  assign one_apart = |(wr_ptr & (rotl(rd_ptr, 1) | rotr(rd_ptr, 1)));
  assign two_apart = |(wr_ptr & (rotl(rd_ptr, 2) | rotr(rd_ptr, 2)));
  assign wr_lost   = ~|wr_ptr;
  assign near_now  = collide ? 3'b100 : one_apart ? 3'b010 : two_apart ? 3'b001 : 3'b000;

  logic a_zero, a_conv, a_data, a_out, col_hold;
  logic [2:0] a_near;
  logic n_zero, n_conv, n_data, n_out, n_hold, cause;
  logic [2:0] n_near;
  logic [15:0] clr;

  always_comb begin
    clr    = clr_we ? clr_data : 16'h0000;
    n_zero = wr_lost | (a_zero & ~clr[15]);
    n_near[0] = near_now[0] | (a_near[0] & ~clr[11]);
    n_near[1] = near_now[1] | (a_near[1] & ~clr[12]);
    n_near[2] = near_now[2] | (a_near[2] & ~(clr[13] & ~col_hold));
    n_conv = conv_clk_lost | (a_conv & ~clr[10]);
    n_data = data_clk_lost | (a_data & ~clr[9]);
    cause  = (en_conv_mute & n_conv) | (en_data_mute & n_data) | (en_col_mute & n_near[2]);
    n_out  = cause | (a_out & ~clr[8]);
    n_hold = collide | (col_hold & ~resync);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_zero   <= 1'b0;
      a_near   <= 3'b000;
      a_conv   <= 1'b0;
      a_data   <= 1'b0;
      a_out    <= 1'b0;
      col_hold <= 1'b0;
    end else begin
      a_zero   <= n_zero;
      a_near   <= n_near;
      a_conv   <= n_conv;
      a_data   <= n_data;
      a_out    <= n_out;
      col_hold <= n_hold;
    end
  end

  assign alarm_word = {a_zero, 1'b0, a_near, a_conv, a_data, a_out, 8'h00};
  assign dout       = a_out ? MID : din;
  assign ptr_load   = resync;
  assign wr_init    = DEPTH'(1);
  assign rd_init    = DEPTH'(1) << RD_OFFSET;

  assert_zero_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr == '0) |=> alarm_word[15]);
  assert_collide_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wr_ptr & rd_ptr)) |=> alarm_word[13]);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_data[10] && !conv_clk_lost) |=> !alarm_word[10]);
  assert_mute_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_data_mute && data_clk_lost) |=> (dout == MID));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_word[13] && col_hold && !resync) |=> alarm_word[13]);
endmodule

// File: tb/fifo_ptr_alarm_mon_test.sv
module fifo_ptr_alarm_mon_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] wr_ptr, rd_ptr;
  logic conv_clk_lost, data_clk_lost, en_conv_mute, en_data_mute, en_col_mute;
  logic resync, clr_we;
  logic [15:0] clr_data, alarm_word, din, dout;
  logic ptr_load;
  logic [7:0] wr_init, rd_init;
  int total = 0, bad = 0;
  bit done = 0;

  fifo_ptr_alarm_mon uut (.clk, .rst_n, .wr_ptr, .rd_ptr, .conv_clk_lost, .data_clk_lost,
    .en_conv_mute, .en_data_mute, .en_col_mute, .resync, .clr_we, .clr_data,
    .alarm_word, .din, .dout, .ptr_load, .wr_init, .rd_init);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    wr_ptr = 8'h01; rd_ptr = 8'h10; resync = 1;
    @(negedge clk);
    resync = 0; clr_we = 1; clr_data = 16'hFFFF;
    @(negedge clk);
    clr_we = 0; clr_data = 0;
  endtask

  initial begin
    wr_ptr = 8'h01; rd_ptr = 8'h10; conv_clk_lost = 0; data_clk_lost = 0;
    en_conv_mute = 0; en_data_mute = 0; en_col_mute = 0; resync = 0;
    clr_we = 0; clr_data = 0; din = 16'h1234;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 word", alarm_word, 0);
    check("R1 dout", dout, 16'h1234);

    // R10 reload values
    resync = 1; #1;
    check("R10 load", ptr_load, 1);
    check("R10 wr_init", wr_init, 8'h01);
    check("R10 rd_init", rd_init, 8'h10);
    resync = 0;

    // R2 R3 R7 sweep over all one-hot pairs
    en_col_mute = 1;
    for (int w = 0; w < 8; w++) begin
      for (int r = 0; r < 8; r++) begin
        int d;
        logic [2:0] exp;
        @(negedge clk);
        wr_ptr = 8'(1 << w); rd_ptr = 8'(1 << r); din = 16'(w * 16'h0111 + r);
        @(negedge clk);
        d = (w - r + 8) % 8;
        if (8 - d < d) d = 8 - d;
        exp = (d == 0) ? 3'b100 : (d == 1) ? 3'b010 : (d == 2) ? 3'b001 : 3'b000;
        check("R2/R3 nearness", alarm_word[13:11], exp);
        check("R7 sweep mute", dout, (d == 0) ? 16'h8000 : din);
        clear_all();
        check("R8 cleared", alarm_word, 0);
      end
    end
    en_col_mute = 0;

    // R4 lost write pointer
    @(negedge clk); wr_ptr = 0;
    @(negedge clk);
    check("R4 set", alarm_word[15], 1);
    clr_we = 1; clr_data = 16'h8000;
    @(negedge clk); clr_we = 0;
    check("R4 persists", alarm_word[15], 1);
    wr_ptr = 8'h01; clr_we = 1;
    @(negedge clk); clr_we = 0;
    check("R4 cleared", alarm_word[15], 0);

    // R5 R6 disabled converter clock loss
    din = 16'h0F0F; conv_clk_lost = 1;
    @(negedge clk); conv_clk_lost = 0;
    check("R5 conv bit", alarm_word[10], 1);
    check("R6 disabled no bit8", alarm_word[8], 0);
    check("R7 not muted", dout, 16'h0F0F);
    clr_we = 1; clr_data = 16'h0000;
    @(negedge clk); clr_we = 0;
    check("R8 zero write", alarm_word[10], 1);
    clr_we = 1; clr_data = 16'h0400;
    @(negedge clk); clr_we = 0;
    check("R8 conv clear", alarm_word[10], 0);

    // R5 R6 R7 enabled data clock loss
    en_data_mute = 1; data_clk_lost = 1;
    @(negedge clk);
    check("R5 data bit", alarm_word[9], 1);
    check("R6 bit8", alarm_word[8], 1);
    check("R7 muted", dout, 16'h8000);
    clr_we = 1; clr_data = 16'h0300;
    @(negedge clk); clr_we = 0;
    check("R8 persists", alarm_word[9:8], 2'b11);
    data_clk_lost = 0;
    @(negedge clk);
    check("R6 sticky bit8", alarm_word[8], 1);
    clr_we = 1; clr_data = 16'h0300;
    @(negedge clk); clr_we = 0;
    check("R8 both cleared", alarm_word[9:8], 2'b00);
    check("R7 unmuted", dout, 16'h0F0F);
    en_data_mute = 0;

    // R9 collision needs resync
    en_col_mute = 1; wr_ptr = 8'h04; rd_ptr = 8'h04;
    @(negedge clk);
    wr_ptr = 8'h01; rd_ptr = 8'h10;
    @(negedge clk);
    clr_we = 1; clr_data = 16'hFFFF;
    @(negedge clk); clr_we = 0;
    check("R9 held", alarm_word[13], 1);
    check("R9 mute held", dout, 16'h8000);
    check("R11 spare bits", alarm_word & 16'h40FF, 0);
    resync = 1;
    @(negedge clk); resync = 0;
    clr_we = 1;
    @(negedge clk); clr_we = 0;
    check("R9 released", alarm_word, 0);
    check("R7 resumes", dout, 16'h0F0F);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule